// File: doc/BRIEF.md
# Dual-Compare Capture Counter

This block is an 8-bit up counter with two compare registers and one capture register. Each compare register has its own four-bit action mask. A match can clear the counter, toggle a shared output flip-flop, raise a one-cycle interrupt pulse, or any mix of these. A match can also be restricted so that it fires only once per start. The counter advances on one of four tick sources: every system clock, a tick from another timer, a tick from an interval timer, or a detected edge on the external input.

The external input is synchronised, then passed through an edge detector whose sensitivity is programmable. A detected edge can restart the counter and re-arm the once-only matches, and it can load the current count into the capture register. Software reads the count as two nibbles. Reading the high nibble snapshots the count into the capture register. Reading the low nibble returns the matching half of that same snapshot, and external captures are held off between the two reads.

Top module: `cmp_capture_timer`

## Requirements
- R1: After reset, tmr_out, irq and rd_nib are 0, the counter and capture register hold 0, and the control register is all zero, so the counter is stopped.
- R2: Control register (address 0) fields are: bits [1:0] tick source (0 every clock, 1 tick_tmr, 2 tick_ivl, 3 detected external edge), bit 2 run, bits [4:3] edge mode, bit 5 external restart enable, bit 6 external capture enable. While run is 1, the counter increments by one on each clock edge at which the selected source is high. While run is 0 the counter holds.
- R3: When a tick finds the count at 255 and no clearing match occurs, the count becomes 0.
- R4: Compare values sit at addresses 1 and 2, and their masks at addresses 3 and 4. Mask bit 0 enables the interrupt, bit 1 clear, bit 2 toggle and bit 3 once-only. A tick that finds the count equal to a compare value is a match. A match with clear set loads 0 in place of the increment.
- R5: A match with toggle set inverts tmr_out at that edge. When both compares toggle at the same edge, the output is left unchanged. A match with the interrupt bit set drives irq high for exactly the following cycle.
- R6: A compare with its once-only bit set produces at most one match between two starts or restarts.
- R7: ext_in passes through a two-stage synchroniser. The edge mode selects which edges count: 0 none, 1 rising, 2 falling, 3 both. A level change that meets clock edge k is acted on at clock edge k+2.
- R8: With restart enabled, a detected edge sets the count to 0, re-arms both once-only compares, and suppresses any tick and match in that cycle.
- R9: With capture enabled, a detected edge loads the pre-edge count into the capture register.
- R10: A read with rd_hi=1 loads the current count into the capture register and returns its bits [7:4] on rd_nib the next cycle. A read with rd_hi=0 returns capture bits [3:0] the next cycle. Otherwise rd_nib holds its value.
- R11: Between a high-nibble read and the next low-nibble read, external capture events do not change the capture register.
- R12: Writing the control register with run=1 while the counter is stopped sets the count to 0 and re-arms both once-only compares.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Count read strobe |
| rd_hi | input | 1 | 1 selects the high nibble (snapshot), 0 the low nibble |
| rd_nib | output | 4 | Read nibble, valid one cycle after the strobe |
| tick_tmr | input | 1 | Tick from another timer (source 1) |
| tick_ivl | input | 1 | Tick from an interval timer (source 2) |
| ext_in | input | 1 | External input, asynchronous |
| tmr_out | output | 1 | Output toggle flip-flop |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The compare logic is first exercised with a single clearing and toggling compare on the system clock. This separates clear-on-match from free wrap, and the 256-count free run checks wrap on its own. A once-only compare is then paired with a shorter clearing compare, so a design that re-fires once-only matches on every period shows up as extra irq pulses and toggles. External edges are swept through all four edge modes with the edge as the tick source, which tells the modes apart by the counts read back. Long random mixes of writes, split reads, tick patterns and input toggles then stress restart, capture and hold interactions against a bench model of the requirements.

// File: rtl/cct_pkg.sv
`timescale 1ns/1ps
package cct_pkg;

  typedef enum logic [1:0] {
    SRC_SYS = 2'd0,
    SRC_TMR = 2'd1,
    SRC_IVL = 2'd2,
    SRC_EXT = 2'd3
  } cct_src_e;

  typedef enum logic [1:0] {
    EDG_OFF  = 2'd0,
    EDG_RISE = 2'd1,
    EDG_FALL = 2'd2,
    EDG_BOTH = 2'd3
  } cct_edge_e;

  typedef struct packed {
    logic      cap_en;
    logic      rst_en;
    cct_edge_e edge_mode;
    logic      run;
    cct_src_e  clk_sel;
  } cct_ctrl_t;

  typedef struct packed {
    logic single;
    logic toggle;
    logic clear;
    logic irq;
  } cct_mask_t;

  localparam int CTRL_W = $bits(cct_ctrl_t);
  localparam int MASK_W = $bits(cct_mask_t);
  localparam int A_CTRL = 0;

endpackage

// File: rtl/cct_edge_det.sv
`timescale 1ns/1ps
module cct_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic                din,
  input  cct_pkg::cct_edge_e  mode,
  output logic                pulse
);
  import cct_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   dly_q, dly_d;
  logic                   rise, fall;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], din};
    dly_d  = sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      dly_q  <= 1'b0;
    end else begin
      sync_q <= sync_d;
      dly_q  <= dly_d;
    end
  end

  always_comb begin
    rise = sync_q[SYNC_STAGES-1] & ~dly_q;
    fall = ~sync_q[SYNC_STAGES-1] & dly_q;
    unique case (mode)
      EDG_OFF:  pulse = 1'b0;
      EDG_RISE: pulse = rise;
      EDG_FALL: pulse = fall;
      EDG_BOTH: pulse = rise | fall;
      default:  pulse = 1'b0;
    endcase
  end
endmodule

// File: rtl/cct_cmp_unit.sv
`timescale 1ns/1ps
module cct_cmp_unit #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             once,
  input  logic             tick,
  input  logic             rearm,
  output logic             hit
);
  logic armed_q, armed_d;

  always_comb begin
    hit     = tick && (count == cmp_val) && (!once || armed_q);
    armed_d = armed_q;
    if (rearm)
      armed_d = 1'b1;
    else if (hit && once)
      armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b1;
    else         armed_q <= armed_d;
  end
endmodule

// File: rtl/cct_capture.sv
`timescale 1ns/1ps
module cct_capture #(
  parameter int CNT_W = 8,
  localparam int NIB_W = CNT_W / 2
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count,
  input  logic             ext_cap,
  input  logic             rd_en,
  input  logic             rd_hi,
  output logic [NIB_W-1:0] rd_nib,
  output logic [CNT_W-1:0] cap_q,
  output logic             hold_q
);
  logic [CNT_W-1:0] cap_d;
  logic             hold_d;
  logic [NIB_W-1:0] nib_q, nib_d;

  always_comb begin
    cap_d  = cap_q;
    hold_d = hold_q;
    nib_d  = nib_q;
    if (rd_en && rd_hi) begin
      cap_d  = count;
      nib_d  = count[CNT_W-1:NIB_W];
      hold_d = 1'b1;
    end else begin
      if (ext_cap && !hold_q)
        cap_d = count;
      if (rd_en) begin
        nib_d  = cap_q[NIB_W-1:0];
        hold_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= '0;
      hold_q <= 1'b0;
      nib_q  <= '0;
    end else begin
      cap_q  <= cap_d;
      hold_q <= hold_d;
      nib_q  <= nib_d;
    end
  end

  assign rd_nib = nib_q;
endmodule

// File: rtl/cmp_capture_timer.sv
`timescale 1ns/1ps
module cmp_capture_timer #(
  parameter int CNT_W       = 8,
  parameter int N_CMP       = 2,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(1 + 2 * N_CMP),
  localparam int NIB_W      = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic              rd_hi,
  output logic [NIB_W-1:0]  rd_nib,
  input  logic              tick_tmr,
  input  logic              tick_ivl,
  input  logic              ext_in,
  output logic              tmr_out,
  output logic              irq
);
  import cct_pkg::*;

  logic [1:0] rst_pipe;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  cct_ctrl_t        ctrl_q, ctrl_d, wr_ctrl;
  logic [CNT_W-1:0] cmp_q  [N_CMP];
  logic [CNT_W-1:0] cmp_d  [N_CMP];
  cct_mask_t        mask_q [N_CMP];
  cct_mask_t        mask_d [N_CMP];

  assign wr_ctrl = cct_ctrl_t'(wr_data[CTRL_W-1:0]);

  always_comb begin
    ctrl_d = ctrl_q;
    for (int i = 0; i < N_CMP; i++) begin
      cmp_d[i]  = cmp_q[i];
      mask_d[i] = mask_q[i];
    end
    if (wr_en) begin
      if (wr_addr == ADDR_W'(A_CTRL)) ctrl_d = wr_ctrl;
      for (int i = 0; i < N_CMP; i++) begin
        if (wr_addr == ADDR_W'(1 + i))         cmp_d[i]  = wr_data;
        if (wr_addr == ADDR_W'(1 + N_CMP + i)) mask_d[i] = cct_mask_t'(wr_data[MASK_W-1:0]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      for (int i = 0; i < N_CMP; i++) begin
        cmp_q[i]  <= '0;
        mask_q[i] <= '0;
      end
    end else begin
      ctrl_q <= ctrl_d;
      for (int i = 0; i < N_CMP; i++) begin
        cmp_q[i]  <= cmp_d[i];
        mask_q[i] <= mask_d[i];
      end
    end
  end

  logic ext_ev;

  cct_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_ni (rst_ni),
    .din    (ext_in),
    .mode   (ctrl_q.edge_mode),
    .pulse  (ext_ev)
  );

  logic src_tick, start, restart, tick;

  always_comb begin
    unique case (ctrl_q.clk_sel)
      SRC_SYS: src_tick = 1'b1;
      SRC_TMR: src_tick = tick_tmr;
      SRC_IVL: src_tick = tick_ivl;
      SRC_EXT: src_tick = ext_ev;
      default: src_tick = 1'b0;
    endcase
    start   = wr_en && (wr_addr == ADDR_W'(A_CTRL)) && wr_ctrl.run && !ctrl_q.run;
    restart = start || (ext_ev && ctrl_q.rst_en);
    tick    = ctrl_q.run && src_tick && !restart;
  end

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [N_CMP-1:0] hit, once;

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    assign once[g] = mask_q[g].single;
    cct_cmp_unit #(.CNT_W(CNT_W)) u_cmp (
      .clk     (clk),
      .rst_ni  (rst_ni),
      .count   (cnt_q),
      .cmp_val (cmp_q[g]),
      .once    (once[g]),
      .tick    (tick),
      .rearm   (restart),
      .hit     (hit[g])
    );
  end

  logic clr_any, tog_par, irq_any;
  logic out_q, out_d, irq_q, irq_d;

  always_comb begin
    clr_any = 1'b0;
    tog_par = 1'b0;
    irq_any = 1'b0;
    for (int i = 0; i < N_CMP; i++) begin
      clr_any = clr_any | (hit[i] & mask_q[i].clear);
      tog_par = tog_par ^ (hit[i] & mask_q[i].toggle);
      irq_any = irq_any | (hit[i] & mask_q[i].irq);
    end
    if (restart)   cnt_d = '0;
    else if (tick) cnt_d = clr_any ? '0 : cnt_q + 1'b1;
    else           cnt_d = cnt_q;
    out_d = out_q ^ tog_par;
    irq_d = irq_any;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      out_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
      irq_q <= irq_d;
    end
  end

  assign tmr_out = out_q;
  assign irq     = irq_q;

  logic [CNT_W-1:0] cap_q;
  logic             cap_hold;

  cct_capture #(.CNT_W(CNT_W)) u_cap (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .count   (cnt_q),
    .ext_cap (ext_ev && ctrl_q.cap_en),
    .rd_en   (rd_en),
    .rd_hi   (rd_hi),
    .rd_nib  (rd_nib),
    .cap_q   (cap_q),
    .hold_q  (cap_hold)
  );
endmodule

// File: rtl/cct_chk.sv
`timescale 1ns/1ps
module cct_chk #(
  parameter int CNT_W = 8,
  parameter int N_CMP = 2
) (
  input logic             clk,
  input logic             rst_ni,
  input logic             run,
  input logic             restart,
  input logic             tick,
  input logic             clr_any,
  input logic             tog_par,
  input logic [CNT_W-1:0] cnt,
  input logic [N_CMP-1:0] hit,
  input logic [N_CMP-1:0] once,
  input logic             out,
  input logic [CNT_W-1:0] cap,
  input logic             hold,
  input logic             rd_en
);
  // R8
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    restart |=> (cnt == '0));

  // R2
  stopped_holds_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!run && !restart) |=> $stable(cnt));

  // R3
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (tick && (cnt == {CNT_W{1'b1}}) && !clr_any) |=> (cnt == '0));

  // R5
  toggle_cause_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(out) |-> $past(tog_par));

  // R11
  cap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (hold && !rd_en) |=> $stable(cap));

  for (genvar g = 0; g < N_CMP; g++) begin : g_once
    // R6
    once_only_chk: assert property (@(posedge clk) disable iff (!rst_ni)
      (hit[g] && once[g]) |=> !hit[g]);
  end
endmodule

bind cmp_capture_timer cct_chk #(.CNT_W(CNT_W), .N_CMP(N_CMP)) u_chk (
  .clk     (clk),
  .rst_ni  (rst_ni),
  .run     (ctrl_q.run),
  .restart (restart),
  .tick    (tick),
  .clr_any (clr_any),
  .tog_par (tog_par),
  .cnt     (cnt_q),
  .hit     (hit),
  .once    (once),
  .out     (out_q),
  .cap     (cap_q),
  .hold    (cap_hold),
  .rd_en   (rd_en)
);

// File: tb/sim_cmp_capture_timer.sv
`timescale 1ns/1ps
module sim_cmp_capture_timer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en, rd_hi, tick_tmr, tick_ivl, ext_in;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [3:0] rd_nib;
  logic       tmr_out, irq;

  always #10 clk = ~clk;

  cmp_capture_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_hi(rd_hi), .rd_nib(rd_nib), .tick_tmr(tick_tmr),
    .tick_ivl(tick_ivl), .ext_in(ext_in), .tmr_out(tmr_out), .irq(irq)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 0;
  string tag   = "R1 reset";

  // reference model state
  logic [7:0] m_cnt, m_cap;
  logic [3:0] m_rd;
  logic       m_out, m_irq, m_hold;
  logic [7:0] m_cmp [2];
  logic [3:0] m_msk [2];
  logic       m_arm [2];
  logic [1:0] m_sel, m_edge;
  logic       m_run, m_rsten, m_capen;
  logic       m_s1, m_s2, m_s3;

  task automatic model_reset();
    m_cnt = 0; m_cap = 0; m_rd = 0; m_out = 0; m_irq = 0; m_hold = 0;
    for (int i = 0; i < 2; i++) begin m_cmp[i] = 0; m_msk[i] = 0; m_arm[i] = 1; end
    m_sel = 0; m_edge = 0; m_run = 0; m_rsten = 0; m_capen = 0;
    m_s1 = 0; m_s2 = 0; m_s3 = 0;
  endtask

  task automatic model_next();
    logic       rise, fall, ev, src, st, rs, tk, clr;
    logic [1:0] h;
    logic [7:0] ncnt, oldcap;
    rise = m_s2 & ~m_s3;
    fall = ~m_s2 & m_s3;
    case (m_edge)
      2'd0: ev = 0;
      2'd1: ev = rise;
      2'd2: ev = fall;
      default: ev = rise | fall;
    endcase
    case (m_sel)
      2'd0: src = 1;
      2'd1: src = tick_tmr;
      2'd2: src = tick_ivl;
      default: src = ev;
    endcase
    st = wr_en && wr_addr == 0 && wr_data[2] && !m_run;
    rs = st || (ev && m_rsten);
    tk = m_run && src && !rs;
    for (int i = 0; i < 2; i++)
      h[i] = tk && (m_cnt == m_cmp[i]) && (!m_msk[i][3] || m_arm[i]);
    clr = (h[0] && m_msk[0][1]) || (h[1] && m_msk[1][1]);
    if (rs)      ncnt = 0;
    else if (tk) ncnt = clr ? 8'd0 : m_cnt + 8'd1;
    else         ncnt = m_cnt;
    for (int i = 0; i < 2; i++) begin
      if (rs) m_arm[i] = 1;
      else if (h[i] && m_msk[i][3]) m_arm[i] = 0;
    end
    m_out = m_out ^ (h[0] & m_msk[0][2]) ^ (h[1] & m_msk[1][2]);
    m_irq = (h[0] & m_msk[0][0]) | (h[1] & m_msk[1][0]);
    oldcap = m_cap;
    if (rd_en && rd_hi) begin
      m_cap = m_cnt; m_rd = m_cnt[7:4]; m_hold = 1;
    end else begin
      if (ev && m_capen && !m_hold) m_cap = m_cnt;
      if (rd_en) begin m_rd = oldcap[3:0]; m_hold = 0; end
    end
    if (wr_en) begin
      case (wr_addr)
        3'd0: begin
          m_sel = wr_data[1:0]; m_run = wr_data[2]; m_edge = wr_data[4:3];
          m_rsten = wr_data[5]; m_capen = wr_data[6];
        end
        3'd1: m_cmp[0] = wr_data;
        3'd2: m_cmp[1] = wr_data;
        3'd3: m_msk[0] = wr_data[3:0];
        3'd4: m_msk[1] = wr_data[3:0];
        default: ;
      endcase
    end
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_in;
    m_cnt = ncnt;
  endtask

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("tmr_out", int'(tmr_out), int'(m_out));
    chk("irq", int'(irq), int'(m_irq));
    chk("rd_nib", int'(rd_nib), int'(m_rd));
  endtask

  task automatic cyc();
    model_next();
    @(negedge clk);
    compare();
  endtask

  task automatic run_n(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1; wr_addr = 3'(a); wr_data = 8'(d);
    cyc();
    wr_en = 0;
  endtask

  task automatic rd_pair();
    rd_en = 1; rd_hi = 1; cyc();
    rd_hi = 0; cyc();
    rd_en = 0; cyc();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h0c0ffee5);
    rst_n = 0; wr_en = 0; rd_en = 0; rd_hi = 0; wr_addr = 0; wr_data = 0;
    tick_tmr = 0; tick_ivl = 0; ext_in = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    compare();
    // R1: reset values and a read of the cleared count
    run_n(4);
    rd_pair();

    // R4 R5: clear + toggle + irq on compare 0 at value 3
    tag = "R4 R5 clear/toggle/irq";
    wr(1, 3); wr(3, 4'b0111); wr(0, 8'h04);
    run_n(9); rd_pair(); run_n(14);

    // R6 R12: once-only compare 1 at 2, compare 0 clears at 9
    tag = "R6 R12 once-only";
    wr(0, 0); wr(2, 2); wr(4, 4'b1101); wr(1, 9); wr(3, 4'b0010); wr(0, 8'h04);
    run_n(40); rd_pair();

    // R8: external rising edge restarts and re-arms
    tag = "R8 external restart";
    wr(0, 8'h2C);
    for (int k = 0; k < 4; k++) begin
      ext_in = ~ext_in; run_n(7); rd_pair();
    end

    // R7: edge modes with edge as tick source
    tag = "R7 edge modes";
    wr(0, 0); wr(3, 0); wr(4, 0);
    for (int md = 0; md < 4; md++) begin
      wr(0, (md << 3) | 8'h07);
      for (int k = 0; k < 7; k++) begin ext_in = ~ext_in; run_n(4); end
      rd_pair();
      wr(0, 0);
    end

    // R2: timer and interval tick sources, then stopped
    tag = "R2 tick sources";
    for (int s = 1; s < 3; s++) begin
      wr(0, 8'h04 | s);
      for (int k = 0; k < 60; k++) begin
        tick_tmr = 1'($urandom); tick_ivl = 1'($urandom); cyc();
      end
      rd_pair();
    end
    wr(0, 8'h01);
    for (int k = 0; k < 20; k++) begin tick_tmr = 1'($urandom); cyc(); end
    rd_pair();

    // R3: free run past 255
    tag = "R3 wrap";
    wr(0, 0); wr(0, 8'h04);
    for (int k = 0; k < 9; k++) begin run_n(34); rd_pair(); end

    // R9 R10 R11: external capture and split read hold
    tag = "R9 R10 R11 capture";
    wr(0, 8'h4C);
    for (int k = 0; k < 3; k++) begin
      ext_in = ~ext_in; run_n(5); rd_en = 1; rd_hi = 0; cyc(); rd_en = 0; cyc();
    end
    rd_en = 1; rd_hi = 1; cyc(); rd_en = 0;
    for (int k = 0; k < 4; k++) begin ext_in = ~ext_in; run_n(5); end
    rd_en = 1; rd_hi = 0; cyc(); rd_en = 0; run_n(2);

    // random mix over all requirements
    tag = "random mix";
    for (int k = 0; k < 5000; k++) begin
      wr_en    = ($urandom % 24) == 0;
      wr_addr  = 3'($urandom % 5);
      wr_data  = 8'($urandom);
      rd_en    = ($urandom % 4) == 0;
      rd_hi    = 1'($urandom);
      tick_tmr = 1'($urandom);
      tick_ivl = 1'($urandom);
      if (($urandom % 6) == 0) ext_in = ~ext_in;
      cyc();
    end
    wr_en = 0; rd_en = 0;
    run_n(4);

    done = 1;
    summary();
    $finish;
  end
endmodule